// File: doc/BRIEF.md
# Multilevel Interrupt Priority Controller

This block chooses which peripheral interrupt request a small processor core takes next. Each request line has a 2-bit level setting of its own. A one-cycle pulse on a request line latches a pending flag. The block then ranks all pending flags, first by level and then by position within the level. The winner is presented to the core as a request with a vector index. The block holds that request until the core acknowledges it.

The block keeps one in-service bit for each of four tiers: low, medium, high and non-maskable. A new request is presented only when its tier is strictly above the highest tier in service, which gives preemption and nesting. A return strobe from the core retires the most recent handler, and the interrupted lower-tier handler resumes. A separate non-maskable input outranks every maskable tier. Each maskable tier has its own enable bit. A mode bit switches the low tier alone from fixed priority to round-robin.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Level field `src_level[2i+1:2i]` of source i encodes 00 = off, 01 = low, 10 = medium, 11 = high. A source set to off is never presented, but its pending flag is kept, so it is presented once it is given a non-zero level.
- R2: Among eligible pending sources, a higher level wins over a lower one. Within one level under fixed priority, the lowest vector index wins.
- R3: A pulse on `nmi_req` is presented with `core_nmi`=1 and `core_vec`=0 ahead of any maskable source, whatever the settings of `lvl_en`.
- R4: `lvl_en` bit 0/1/2 enables the low/medium/high tier. While a tier's bit is clear, its sources are never presented but stay pending.
- R5: A maskable request is presented only if its tier is strictly above the highest tier in `in_service`. Requests at the same or a lower tier wait.
- R6: Once `core_irq` is raised, it stays high with `core_vec` and `core_nmi` unchanged until a cycle with `core_ack`=1. That cycle clears the presented source's pending flag and sets its tier's bit in `in_service`.
- R7: A `core_reti` pulse clears the highest set bit of `in_service` (bit 3 = NMI, 2 = high, 1 = medium, 0 = low). This makes the next lower tier the running one again.
- R8: With `rr_mode`=1, the low tier searches from the index just after the last acknowledged low source and wraps around. The most recently served source therefore has the lowest priority.
- R9: The medium and high tiers keep fixed lowest-index priority even when `rr_mode`=1.
- R10: After reset, `core_irq`=0 and `in_service`=0, and the first round-robin search starts at index 0.
- R11: Only a set NMI bit in `in_service` holds back a further pending NMI, and that NMI is presented once the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | N_SRC | Per-source request pulses that latch pending flags |
| src_level | input | 2*N_SRC | Per-source 2-bit level fields |
| lvl_en | input | 3 | Enable bits for the low, medium and high tiers |
| rr_mode | input | 1 | 1 selects round-robin for the low tier |
| nmi_req | input | 1 | Non-maskable request pulse |
| core_ack | input | 1 | Core accepts the presented interrupt |
| core_reti | input | 1 | Core returns from the current handler |
| core_irq | output | 1 | Interrupt presented to the core |
| core_vec | output | IDX_W | Vector index of the presented source |
| core_nmi | output | 1 | Presented interrupt is the non-maskable one |
| in_service | output | 4 | In-service bits: NMI, high, medium, low (MSB first) |

## Verification
The bench builds the block with N_SRC = 4. At that size, all 256 combinations of the four level fields can be swept with every source pending, and each outcome is compared with an arithmetic ranking. The small source count also makes a full round-robin wrap take only a handful of acknowledge/return rounds. Nesting across all four tiers, gating by the tier enables and blocking of the non-maskable input all fit within a few short directed sequences.

// File: rtl/irq_pkg.sv
// Shared types for the interrupt priority controller.
package irq_pkg;
    typedef enum logic [1:0] {
        LVL_OFF = 2'b00,
        LVL_LO  = 2'b01,
        LVL_MED = 2'b10,
        LVL_HI  = 2'b11
    } irq_lvl_e;

    // Tier slot numbers, which are also in_service bit positions.
    localparam logic [1:0] SLOT_LO  = 2'd0;
    localparam logic [1:0] SLOT_MED = 2'd1;
    localparam logic [1:0] SLOT_HI  = 2'd2;
    localparam logic [1:0] SLOT_NMI = 2'd3;
endpackage

// File: rtl/irq_level_pick.sv
// Picks one candidate within a single tier.
// Assumes: cand marks pending sources of this tier. With ALLOW_RR, rr_on
// starts the search just after last_idx and wraps; otherwise lowest index.
module irq_level_pick #(
    parameter int N_SRC    = 8,
    parameter int IDX_W    = 3,
    parameter bit ALLOW_RR = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] cand,
    input  logic             rr_on,
    input  logic [IDX_W-1:0] last_idx,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] low_idx;

    // Lowest-index candidate (fixed priority).
    always_comb begin
        low_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i]) low_idx = IDX_W'(i);
        end
    end

    assign hit = |cand;

    generate
        if (ALLOW_RR) begin : g_rr
            logic [IDX_W-1:0] after_idx;
            logic             after_hit;

            // Lowest-index candidate strictly above the last served index.
            always_comb begin
                after_idx = '0;
                after_hit = 1'b0;
                for (int i = N_SRC - 1; i >= 0; i--) begin
                    if (cand[i] && (IDX_W'(i) > last_idx)) begin
                        after_idx = IDX_W'(i);
                        after_hit = 1'b1;
                    end
                end
            end

            // Round-robin result wraps to the lowest index when nothing is above.
            assign idx = (rr_on && after_hit) ? after_idx : low_idx;
        end else begin : g_static
            assign idx = low_idx;
        end
    endgenerate

    // R2: a reported pick is always a real candidate
    p_pick_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> cand[idx]);
endmodule

// File: rtl/irq_insvc_track.sv
// Keeps the four in-service bits and reports the highest running tier.
// Assumes: set_mask is one-hot or zero. pop clears the highest set bit
// of the state as it was before this cycle's set.
module irq_insvc_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] set_mask,
    input  logic       pop,
    output logic [3:0] insvc,
    output logic [2:0] cur_rank
);
    logic [3:0] top_bit;

    // One-hot of the highest set in-service bit.
    always_comb begin
        top_bit = '0;
        for (int i = 0; i < 4; i++) begin
            if (insvc[i]) top_bit = 4'(1 << i);
        end
    end

    // Rank: 0 when idle, else 1 + highest set slot.
    always_comb begin
        cur_rank = 3'd0;
        for (int i = 0; i < 4; i++) begin
            if (insvc[i]) cur_rank = 3'(i + 1);
        end
    end

    // In-service state update.
    always_ff @(posedge clk) begin
        if (!rst_n) insvc <= '0;
        else        insvc <= (insvc & ~(pop ? top_bit : 4'b0)) | set_mask;
    end

    // R7: a return with no new set drops exactly one in-service bit
    p_reti_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (insvc != 4'b0) && (set_mask == 4'b0))
        |=> ($countones(insvc) == $countones($past(insvc)) - 1));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Multilevel interrupt priority controller (top).
// Assumes: src_req and nmi_req are pulses that latch pending flags. The core
// pulses core_ack while core_irq is high and core_reti once per finished
// handler.
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_req,
    input  logic [2*N_SRC-1:0] src_level,
    input  logic [2:0]         lvl_en,
    input  logic               rr_mode,
    input  logic               nmi_req,
    input  logic               core_ack,
    input  logic               core_reti,
    output logic               core_irq,
    output logic [IDX_W-1:0]   core_vec,
    output logic               core_nmi,
    output logic [3:0]         in_service
);
    logic [N_SRC-1:0] pending;
    logic             nmi_pend;
    logic [IDX_W-1:0] rr_last;
    logic [N_SRC-1:0] cand_lo, cand_med, cand_hi;
    logic             hit_lo, hit_med, hit_hi;
    logic [IDX_W-1:0] idx_lo, idx_med, idx_hi;
    logic [2:0]       cur_rank;
    logic             hold_valid, hold_nmi;
    logic [IDX_W-1:0] hold_vec;
    logic [1:0]       hold_slot;
    logic             win;
    logic             win_nmi;
    logic [IDX_W-1:0] win_vec;
    logic [1:0]       win_slot;
    logic             fire;
    logic [3:0]       set_mask;
    logic [N_SRC-1:0] clr_mask;

    // Split pending sources into per-tier candidate vectors.
    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_split
            assign cand_lo[g]  = pending[g] && (irq_lvl_e'(src_level[2*g +: 2]) == LVL_LO);
            assign cand_med[g] = pending[g] && (irq_lvl_e'(src_level[2*g +: 2]) == LVL_MED);
            assign cand_hi[g]  = pending[g] && (irq_lvl_e'(src_level[2*g +: 2]) == LVL_HI);
        end
    endgenerate

    irq_level_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W), .ALLOW_RR(1'b1)) u_pick_lo (
        .clk(clk), .rst_n(rst_n), .cand(cand_lo), .rr_on(rr_mode),
        .last_idx(rr_last), .hit(hit_lo), .idx(idx_lo));
    irq_level_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W), .ALLOW_RR(1'b0)) u_pick_med (
        .clk(clk), .rst_n(rst_n), .cand(cand_med), .rr_on(rr_mode),
        .last_idx(rr_last), .hit(hit_med), .idx(idx_med));
    irq_level_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W), .ALLOW_RR(1'b0)) u_pick_hi (
        .clk(clk), .rst_n(rst_n), .cand(cand_hi), .rr_on(rr_mode),
        .last_idx(rr_last), .hit(hit_hi), .idx(idx_hi));

    irq_insvc_track u_insvc (
        .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .pop(core_reti),
        .insvc(in_service), .cur_rank(cur_rank));

    // Cross-tier choice: NMI, then high, medium, low, each gated by enable and rank.
    always_comb begin
        win      = 1'b0;
        win_nmi  = 1'b0;
        win_vec  = '0;
        win_slot = SLOT_LO;
        if (nmi_pend && !in_service[SLOT_NMI]) begin
            win = 1'b1; win_nmi = 1'b1; win_slot = SLOT_NMI;
        end else if (hit_hi && lvl_en[2] && cur_rank < 3'd3) begin
            win = 1'b1; win_vec = idx_hi; win_slot = SLOT_HI;
        end else if (hit_med && lvl_en[1] && cur_rank < 3'd2) begin
            win = 1'b1; win_vec = idx_med; win_slot = SLOT_MED;
        end else if (hit_lo && lvl_en[0] && cur_rank < 3'd1) begin
            win = 1'b1; win_vec = idx_lo; win_slot = SLOT_LO;
        end
    end

    assign fire     = core_ack && hold_valid;
    assign set_mask = fire ? 4'(1 << hold_slot) : 4'b0;
    assign clr_mask = (fire && !hold_nmi) ? N_SRC'(1) << hold_vec : '0;

    // Pending flags: new pulses set, acknowledge of the presented source clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= '0;
            nmi_pend <= 1'b0;
        end else begin
            pending  <= (pending & ~clr_mask) | src_req;
            nmi_pend <= (nmi_pend && !(fire && hold_nmi)) || nmi_req;
        end
    end

    // Round-robin pointer: remembers the last acknowledged low-tier source.
    always_ff @(posedge clk) begin
        if (!rst_n)                             rr_last <= IDX_W'(N_SRC - 1);
        else if (fire && hold_slot == SLOT_LO)  rr_last <= hold_vec;
    end

    // Presentation register: load a winner when idle, drop it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_nmi   <= 1'b0;
            hold_vec   <= '0;
            hold_slot  <= SLOT_LO;
        end else if (fire) begin
            hold_valid <= 1'b0;
        end else if (!hold_valid && win) begin
            hold_valid <= 1'b1;
            hold_nmi   <= win_nmi;
            hold_vec   <= win_vec;
            hold_slot  <= win_slot;
        end
    end

    assign core_irq = hold_valid;
    assign core_vec = hold_vec;
    assign core_nmi = hold_nmi;

    // R6: presented request is held unchanged until acknowledged
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq && !core_ack) |=> (core_irq && $stable(core_vec) && $stable(core_nmi)));

    // R5: a maskable request is raised only above the running tier
    p_preempt_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_irq) && !core_nmi) |-> ($past(cur_rank) <= {1'b0, hold_slot}));

    // R11: an NMI is never raised while an NMI handler runs
    p_nmi_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_irq) && core_nmi) |-> !$past(in_service[SLOT_NMI]));

    // R3: the NMI presentation carries vector zero
    p_nmi_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq && core_nmi) |-> (core_vec == '0));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic [2*N-1:0] src_level = '0;
    logic [2:0]   lvl_en = 3'b111;
    logic         rr_mode = 1'b0;
    logic         nmi_req = 1'b0;
    logic         core_ack = 1'b0;
    logic         core_reti = 1'b0;
    logic         core_irq;
    logic [1:0]   core_vec;
    logic         core_nmi;
    logic [3:0]   in_service;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.N_SRC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_level(src_level),
        .lvl_en(lvl_en), .rr_mode(rr_mode), .nmi_req(nmi_req),
        .core_ack(core_ack), .core_reti(core_reti), .core_irq(core_irq),
        .core_vec(core_vec), .core_nmi(core_nmi), .in_service(in_service));

    task automatic chk(input int act, input int exp, input string tag);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input logic [N-1:0] m);
        src_req = m;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic pulse_nmi();
        nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
    endtask

    task automatic ack();
        core_ack = 1'b1;
        @(negedge clk);
        core_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic reti();
        core_reti = 1'b1;
        @(negedge clk);
        core_reti = 1'b0;
    endtask

    // Expected vector from arithmetic ranking: highest level, then lowest index.
    function automatic int exp_vec(input int cfg);
        int best = 0;
        int v = -1;
        for (int i = 0; i < N; i++) begin
            int l = (cfg >> (2 * i)) & 3;
            if (l > best) begin best = l; v = i; end
        end
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        chk(core_irq, 0, "R10 irq after reset");
        chk(in_service, 0, "R10 in_service after reset");

        // R1, R2: sweep all level configurations with every source pending
        for (int cfg = 0; cfg < 256; cfg++) begin
            int e;
            do_reset();
            src_level = 8'(cfg);
            pulse(4'b1111);
            settle();
            e = exp_vec(cfg);
            if (e < 0) chk(core_irq, 0, "R1 all sources off");
            else begin
                chk(core_irq, 1, "R2 irq raised");
                chk(core_vec, e, "R2 winning vector");
            end
        end

        // R1: an off source keeps its pending flag
        do_reset();
        src_level = 8'b00_00_00_00;
        pulse(4'b0100);
        settle();
        chk(core_irq, 0, "R1 off source silent");
        src_level = 8'b00_01_00_00;
        settle();
        chk(core_irq, 1, "R1 pending kept");
        chk(core_vec, 2, "R1 pending kept vec");

        // R4: tier enable gating
        do_reset();
        lvl_en = 3'b110;
        src_level = 8'b00_00_00_01;
        pulse(4'b0001);
        settle();
        chk(core_irq, 0, "R4 disabled tier");
        lvl_en = 3'b111;
        settle();
        chk(core_irq, 1, "R4 enabled tier");
        chk(core_vec, 0, "R4 enabled vec");

        // R6, R5, R7: nesting low -> high, medium waits, resumes after return
        do_reset();
        src_level = 8'b00_10_11_01;
        pulse(4'b0001);
        settle();
        repeat (4) @(negedge clk);
        chk(core_irq, 1, "R6 held without ack");
        chk(core_vec, 0, "R6 vec held");
        ack();
        chk(in_service, 4'b0001, "R6 low in service");
        chk(core_irq, 0, "R6 cleared by ack");
        pulse(4'b0010);
        settle();
        chk(core_vec, 1, "R5 high preempts low");
        chk(core_irq, 1, "R5 high raised");
        ack();
        chk(in_service, 4'b0101, "R6 high in service");
        pulse(4'b0100);
        settle();
        chk(core_irq, 0, "R5 medium waits under high");
        reti();
        settle();
        chk(in_service, 4'b0001, "R7 high popped");
        chk(core_irq, 1, "R7 medium after return");
        chk(core_vec, 2, "R7 medium vec");

        // R3, R11: NMI ignores enables, blocked only by its own bit
        do_reset();
        lvl_en = 3'b000;
        src_level = 8'b00_00_00_11;
        pulse(4'b0001);
        pulse_nmi();
        settle();
        chk(core_irq, 1, "R3 nmi raised");
        chk(core_nmi, 1, "R3 nmi flag");
        chk(core_vec, 0, "R3 nmi vec");
        ack();
        chk(in_service, 4'b1000, "R3 nmi in service");
        pulse_nmi();
        settle();
        chk(core_irq, 0, "R11 nmi blocked by nmi");
        reti();
        settle();
        chk(core_irq, 1, "R11 nmi after return");
        chk(core_nmi, 1, "R11 nmi flag again");
        lvl_en = 3'b111;

        // R8: round-robin across four low sources
        do_reset();
        rr_mode = 1'b1;
        src_level = 8'b01_01_01_01;
        pulse(4'b1111);
        for (int k = 0; k < 6; k++) begin
            settle();
            chk(core_vec, k % N, "R8 round-robin order");
            ack();
            chk(core_irq, 0, "R5 same tier waits");
            src_req = 4'(1 << (k % N));
            core_reti = 1'b1;
            @(negedge clk);
            src_req = '0;
            core_reti = 1'b0;
        end

        // R9: medium stays fixed with round-robin on
        do_reset();
        rr_mode = 1'b1;
        src_level = 8'b00_00_10_10;
        pulse(4'b0011);
        for (int k = 0; k < 3; k++) begin
            settle();
            chk(core_vec, 0, "R9 medium static");
            ack();
            src_req = 4'b0001;
            core_reti = 1'b1;
            @(negedge clk);
            src_req = '0;
            core_reti = 1'b0;
        end

        // R2: fixed low priority without round-robin
        do_reset();
        rr_mode = 1'b0;
        src_level = 8'b01_01_01_01;
        pulse(4'b1110);
        settle();
        chk(core_vec, 1, "R2 static low lowest index");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule